// File: doc/BRIEF.md
# Dual Retriggerable Pulse Stretcher with Clear

This block turns a single qualifying input transition into an output pulse of fixed length, measured in clock cycles. It holds two identical channels that share only the clock and the global reset. Each channel has two trigger inputs of opposite sense. The first fires on a falling edge and only counts while the second input is high. The second fires on a rising edge and only counts while the first input is low. A per-channel length value sets how long the pulse lasts. Each channel also has its own active-low clear, which ends a running pulse at once and blocks new triggers while it is held low.

A trigger that arrives during a running pulse reloads the timer with the full length. A steady stream of triggers can therefore keep the output high without a break. Every input first passes through a synchronizer chain, and edges are detected on the synchronized copies. All results therefore appear a fixed number of cycles after the inputs are sampled. Each channel drives a true output and a complementary output.

Top module: `oneshot_dual`

## Requirements
- R1: When neg_trig_i is sampled low at clock edge k after being sampled high at edge k-1, and pos_trig_i is sampled high at edge k, pulse_o goes high after edge k+2.
- R2: When pos_trig_i is sampled high at edge k after being sampled low at edge k-1, and neg_trig_i is sampled low at edge k, pulse_o goes high after edge k+2.
- R3: The following cause no pulse: a falling neg_trig_i while pos_trig_i is low, a rising pos_trig_i while neg_trig_i is high, a rising neg_trig_i, and a falling pos_trig_i.
- R4: After the last trigger, pulse_o stays high for exactly N consecutive cycles, where N is the channel's 16-bit slice len_i[16c+15:16c].
- R5: A trigger during an active pulse reloads the full N. Triggers spaced fewer than N cycles apart keep pulse_o high without a gap.
- R6: A trigger that is loaded while N = 0 produces no pulse.
- R7: When clr_n_i is sampled low at edge k, pulse_o is low after edge k+2, whatever the state of the timer.
- R8: Triggers whose edge is sampled while clr_n_i is sampled low are ignored, including an edge in the same cycle that clear falls. After clear is released, only edges sampled later can start a pulse.
- R9: pulse_n_o is always the bitwise inverse of pulse_o.
- R10: The two channels are independent. Stimulus on one channel never changes the other channel's outputs.
- R11: While rst is high and for three cycles after it falls, pulse_o is low. Input levels held across reset are not taken as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| neg_trig_i | input | NUM_CH | Falling-edge trigger, one bit per channel |
| pos_trig_i | input | NUM_CH | Rising-edge trigger, one bit per channel |
| clr_n_i | input | NUM_CH | Active-low clear, one bit per channel |
| len_i | input | NUM_CH*CNT_W | Pulse length per channel, channel c in bits [CNT_W*c +: CNT_W] |
| pulse_o | output | NUM_CH | True pulse output |
| pulse_n_o | output | NUM_CH | Complementary pulse output |

## Verification
Trigger and clear inputs sampled at edge k act on the outputs after edge k+2. The length value acts at the load edge itself, so its effect is visible after edge k+2 as well. The bench keeps a behavioural model that records each sampled input pair and holds the resulting event in a two-deep delay line. The model applies the event at edge k+2, then compares both outputs at the following falling clock edge. Directed phases tag the per-cycle comparisons with the requirement under test. A random phase then mixes triggers, clears and length changes on both channels.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronized per-channel input bundle
    typedef struct packed {
        logic neg_in;   // falling-edge trigger level
        logic pos_in;   // rising-edge trigger level
        logic clr_n;    // active-low clear level
    } trig_in_t;

    localparam int TRIG_W = $bits(trig_in_t);

    // Command from the edge detector to the timer
    typedef enum logic [1:0] {
        TMR_HOLD = 2'd0,
        TMR_LOAD = 2'd1,
        TMR_KILL = 2'd2
    } tmr_cmd_e;

    // Qualified edge: falling neg while pos high, or rising pos while neg low
    function automatic logic trig_event(trig_in_t prev, trig_in_t cur);
        logic fall_hit;
        logic rise_hit;
        fall_hit = prev.neg_in & ~cur.neg_in & cur.pos_in;
        rise_hit = ~prev.pos_in & cur.pos_in & ~cur.neg_in;
        return fall_hit | rise_hit;
    endfunction

    // Clear has priority over any trigger in the same cycle
    function automatic tmr_cmd_e pick_cmd(logic armed, trig_in_t prev, trig_in_t cur);
        if (!cur.clr_n) begin
            return TMR_KILL;
        end
        if (armed && trig_event(prev, cur)) begin
            return TMR_LOAD;
        end
        return TMR_HOLD;
    endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RST_VAL;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/os_trig_detect.sv
module os_trig_detect
    import oneshot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     armed,
    input  trig_in_t cur,
    output tmr_cmd_e cmd
);

    trig_in_t prev_q;

    // The previous sample keeps tracking during clear, so edges seen
    // while clear is low are consumed and never replayed later.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    always_comb begin
        cmd = pick_cmd(armed, prev_q, cur);
    end

endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_cmd_e         cmd,
    input  logic [CNT_W-1:0] len,
    output logic             active
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (cmd)
                TMR_KILL: cnt_q <= '0;
                TMR_LOAD: cnt_q <= len;
                default:  if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            endcase
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/os_channel.sv
module os_channel
    import oneshot_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic             neg_trig,
    input  logic             pos_trig,
    input  logic             clr_n,
    input  logic [CNT_W-1:0] len,
    output logic             pulse,
    output logic             pulse_n
);

    logic [TRIG_W-1:0] sync_q;
    trig_in_t          cur;
    tmr_cmd_e          cmd;
    logic              active;

    os_sync #(
        .WIDTH   (TRIG_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({neg_trig, pos_trig, clr_n}),
        .q   (sync_q)
    );

    assign cur = trig_in_t'(sync_q);

    os_trig_detect u_det (
        .clk   (clk),
        .rst   (rst),
        .armed (armed),
        .cur   (cur),
        .cmd   (cmd)
    );

    os_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .len    (len),
        .active (active)
    );

    assign pulse   = active;
    assign pulse_n = ~active;

endmodule

// File: rtl/oneshot_dual.sv
module oneshot_dual #(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       neg_trig_i,
    input  logic [NUM_CH-1:0]       pos_trig_i,
    input  logic [NUM_CH-1:0]       clr_n_i,
    input  logic [NUM_CH*CNT_W-1:0] len_i,
    output logic [NUM_CH-1:0]       pulse_o,
    output logic [NUM_CH-1:0]       pulse_n_o
);

    // Edge detection is enabled only once the synchronizers and the
    // previous-sample register all hold post-reset input samples.
    localparam int ARM_W = SYNC_STAGES + 1;

    logic [ARM_W-1:0] arm_q;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) arm_q <= '0;
        else     arm_q <= {arm_q[ARM_W-2:0], 1'b1};
    end

    assign armed = arm_q[ARM_W-1];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            os_channel #(
                .CNT_W       (CNT_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_ch (
                .clk      (clk),
                .rst      (rst),
                .armed    (armed),
                .neg_trig (neg_trig_i[c]),
                .pos_trig (pos_trig_i[c]),
                .clr_n    (clr_n_i[c]),
                .len      (len_i[c*CNT_W +: CNT_W]),
                .pulse    (pulse_o[c]),
                .pulse_n  (pulse_n_o[c])
            );
        end
    endgenerate

endmodule

// File: rtl/oneshot_dual_chk.sv
module oneshot_dual_chk #(
    parameter int NUM_CH      = 2,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CH-1:0]       neg_trig_i,
    input logic [NUM_CH-1:0]       pos_trig_i,
    input logic [NUM_CH-1:0]       clr_n_i,
    input logic [NUM_CH*CNT_W-1:0] len_i,
    input logic [NUM_CH-1:0]       pulse_o
);

    localparam int LAT = SYNC_STAGES + 1;

    logic [3:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)                since_q <= '0;
        else if (since_q != 4'hF) since_q <= since_q + 1'b1;
    end

    // R11: quiet output right after reset
    assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (since_q <= 4'(LAT)) |-> (pulse_o == '0));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R1 and R2: a rising pulse must come from a qualified edge
            assert_trig_source_R1: assert property (@(posedge clk) disable iff (rst)
                ((since_q >= 4'(LAT + 2)) && $rose(pulse_o[i])) |->
                ($past(clr_n_i[i], LAT) &&
                 (($past(neg_trig_i[i], LAT + 1) && !$past(neg_trig_i[i], LAT) && $past(pos_trig_i[i], LAT)) ||
                  (!$past(pos_trig_i[i], LAT + 1) && $past(pos_trig_i[i], LAT) && !$past(neg_trig_i[i], LAT)))));

            // R7: clear ends the pulse after the fixed latency
            assert_clear_ends_R7: assert property (@(posedge clk) disable iff (rst)
                ((since_q >= 4'(LAT + 1)) && !$past(clr_n_i[i], LAT)) |-> !pulse_o[i]);

            // R6: a pulse never starts from a zero length
            assert_zero_len_R6: assert property (@(posedge clk) disable iff (rst)
                ((since_q >= 4'(LAT + 1)) && $rose(pulse_o[i])) |->
                ($past(len_i[i*CNT_W +: CNT_W], 1) != '0));
        end
    endgenerate

endmodule

bind oneshot_dual oneshot_dual_chk #(
    .NUM_CH      (NUM_CH),
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .neg_trig_i (neg_trig_i),
    .pos_trig_i (pos_trig_i),
    .clr_n_i    (clr_n_i),
    .len_i      (len_i),
    .pulse_o    (pulse_o)
);

// File: tb/test_oneshot_dual.sv
`timescale 1ns/1ps
module test_oneshot_dual;

    localparam int NCH = 2;
    localparam int W   = 16;

    logic               clk = 1'b0;
    logic               rst;
    logic [NCH-1:0]     neg, pos, clrn;
    logic [NCH*W-1:0]   len;
    logic [NCH-1:0]     pulse, pulse_n;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R11";

    // behavioural model state
    int   m_cnt  [NCH];
    logic m_ev   [NCH][2];
    logic m_kill [NCH][2];
    logic p_neg  [NCH];
    logic p_pos  [NCH];
    int   since = 0;

    always #4 clk = ~clk;

    oneshot_dual #(.NUM_CH(NCH), .CNT_W(W), .SYNC_STAGES(2)) i_oneshot_dual (
        .clk        (clk),
        .rst        (rst),
        .neg_trig_i (neg),
        .pos_trig_i (pos),
        .clr_n_i    (clrn),
        .len_i      (len),
        .pulse_o    (pulse),
        .pulse_n_o  (pulse_n)
    );

    function automatic logic fires(logic pn, logic pp, logic cn, logic cp);
        return (pn && !cn && cp) || (!pp && cp && !cn);
    endfunction

    task automatic chk(string req, int c, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d: got %0d expected %0d at %0t", req, c, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            since = 0;
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0;
                m_ev[c][0] = 0; m_ev[c][1] = 0;
                m_kill[c][0] = 0; m_kill[c][1] = 0;
            end
        end else begin
            since++;
            for (int c = 0; c < NCH; c++) begin
                if (m_kill[c][1])      m_cnt[c] = 0;
                else if (m_ev[c][1])   m_cnt[c] = int'(len[c*W +: W]);
                else if (m_cnt[c] > 0) m_cnt[c]--;
                m_kill[c][1] = m_kill[c][0];
                m_ev[c][1]   = m_ev[c][0];
                m_kill[c][0] = !clrn[c];
                m_ev[c][0]   = (since >= 2) && clrn[c] && fires(p_neg[c], p_pos[c], neg[c], pos[c]);
            end
        end
        for (int c = 0; c < NCH; c++) begin
            p_neg[c] = neg[c];
            p_pos[c] = pos[c];
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            chk(cur_req, c, int'(pulse[c]), (m_cnt[c] != 0) ? 1 : 0);
            chk("R9", c, int'(pulse_n[c]), (m_cnt[c] != 0) ? 0 : 1);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_len(int c, int v);
        len[c*W +: W] = 16'(v);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        int unsigned seed_set;
        seed_set = $urandom(32'd20517);
        rst  = 1'b1;
        neg  = 2'b11;
        pos  = 2'b00;
        clrn = 2'b11;
        len  = '0;
        set_len(0, 5);
        set_len(1, 4);

        // R11: levels that resemble edges are held across reset
        cur_req = "R11";
        neg[0] = 1'b0; pos[0] = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(8);
        neg[0] = 1'b1; pos[0] = 1'b0;
        cyc(4);

        // R3: gated or wrong-direction edges
        cur_req = "R3";
        pos[0] = 1'b1; cyc(4);
        pos[0] = 1'b0; cyc(4);
        neg[0] = 1'b0; cyc(4);
        neg[0] = 1'b1; cyc(4);

        // R1: falling neg with pos high
        cur_req = "R1";
        pos[0] = 1'b1; cyc(3);
        neg[0] = 1'b0; cyc(10);
        neg[0] = 1'b1; pos[0] = 1'b0; cyc(3);

        // R2: rising pos with neg low
        cur_req = "R2";
        neg[0] = 1'b0; cyc(3);
        pos[0] = 1'b1; cyc(9);
        neg[0] = 1'b1; pos[0] = 1'b0; cyc(3);

        // R4: exact width count
        cur_req = "R4";
        set_len(0, 7);
        pos[0] = 1'b1; cyc(2);
        neg[0] = 1'b0;
        hi = 0;
        for (int i = 0; i < 14; i++) begin
            step();
            if (pulse[0]) hi++;
        end
        chk("R4", 0, hi, 7);

        // R5: retrigger every 3 cycles with length 5
        cur_req = "R5";
        set_len(0, 5);
        for (int i = 0; i < 8; i++) begin
            neg[0] = 1'b1; cyc(1);
            neg[0] = 1'b0; cyc(2);
        end
        chk("R5", 0, int'(pulse[0]), 1);
        cyc(10);

        // R6: zero length
        cur_req = "R6";
        set_len(0, 0);
        neg[0] = 1'b1; cyc(1);
        neg[0] = 1'b0; cyc(8);

        // R7: clear ends a long pulse
        cur_req = "R7";
        set_len(0, 40);
        neg[0] = 1'b1; cyc(1);
        neg[0] = 1'b0; cyc(6);
        clrn[0] = 1'b0; cyc(3);
        chk("R7", 0, int'(pulse[0]), 0);
        cyc(2);

        // R8: triggers during clear, coincident edge, release
        cur_req = "R8";
        for (int i = 0; i < 3; i++) begin
            neg[0] = 1'b1; cyc(1);
            neg[0] = 1'b0; cyc(1);
        end
        neg[0] = 1'b1; cyc(1);
        neg[0] = 1'b0; cyc(1);
        clrn[0] = 1'b1; cyc(6);
        chk("R8", 0, int'(pulse[0]), 0);
        neg[0] = 1'b1; cyc(3);
        neg[0] = 1'b0; clrn[0] = 1'b0; cyc(5);
        clrn[0] = 1'b1; cyc(6);
        chk("R8", 0, int'(pulse[0]), 0);
        neg[0] = 1'b1; cyc(1);
        neg[0] = 1'b0; cyc(4);
        chk("R8", 0, int'(pulse[0]), 1);
        cyc(40);

        // R11: reset in the middle of a pulse
        cur_req = "R11";
        set_len(0, 30);
        neg[0] = 1'b1; cyc(1);
        neg[0] = 1'b0; cyc(5);
        rst = 1'b1; cyc(2);
        rst = 1'b0; cyc(8);

        // R10: random traffic on both channels
        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(5) == 0) neg[c] = ~neg[c];
                if ($urandom_range(5) == 0) pos[c] = ~pos[c];
                if ($urandom_range(39) == 0) clrn[c] = ~clrn[c];
                if ($urandom_range(63) == 0) set_len(c, int'($urandom_range(12)));
            end
            step();
        end

        finish_run();
    end

endmodule